// File: doc/BRIEF.md
# Phase Accumulator Core with Selectable Profiles

This block is the numeric heart of a direct digital synthesizer. A 32-bit phase accumulator advances by the active frequency tuning word on every clock, so the output frequency is the tuning word times the clock rate divided by 2^32. For linear frequency sweeps, a second 32-bit frequency accumulator adds a delta word at a programmable ramp-rate pace. In sweep mode its value is added to the tuning word. Four profiles each hold a tuning word and a 14-bit phase offset. A registered 2-bit select input picks the active profile.

Every host write lands in a holding register. Nothing written changes the running synthesis until the update strobe copies all holding values into the active set. The one exception is the ramp-rate word, when the control word asks for it to load at once. Control bits can clear either accumulator on the strobe, or hold either accumulator at zero for as long as they stay set. The output is the top 14 bits of the phase accumulator plus the profile's phase offset, ready for a later sine or cosine lookup.

Top module: `dds_accum_core`

## Requirements
- R1: While `rst_n` is low, all registers are zero and `phase_word` is 0. After `rst_n` rises, the first two clock edges still hold the reset state, and normal operation starts at the third edge.
- R2: Register map on `wr_addr`:
  - 0..3: tuning word of profiles 0..3.
  - 4..7: phase offset of profiles 0..3, taken from `wr_data[13:0]`.
  - 8: sweep delta word.
  - 9: ramp-rate word, taken from `wr_data[15:0]`.
  - 10: control word, taken from `wr_data[5:0]`.

  A write only updates the holding register. With `upd_stb` low, the active values and `phase_word` do not change because of it. A cycle with `upd_stb` high copies every holding register to its active register.
- R3: A tuning word written above 0x8000_0000 is stored as 0x8000_0000.
- R4: `prof_sel` is registered. The profile it names is used for the accumulation and the output from the next clock edge on. Writing a profile does not select it.
- R5: On each edge, the phase accumulator adds the active profile's tuning word, plus the frequency accumulator when control bit 0 (sweep) is active, modulo 2^32. `phase_word` equals the accumulator's top 14 bits plus the active profile's phase offset, modulo 2^14.
- R6: On an update cycle, if the control word being loaded has bit 1 set, the frequency accumulator becomes 0. If it has bit 2 set, the phase accumulator becomes 0. Accumulation then restarts from zero at the new rates.
- R7: Without those bits, an update cycle leaves both accumulators continuing from their held values.
- R8: While control bit 3 is in effect, the frequency accumulator is held at 0. While control bit 4 is in effect, the phase accumulator is held at 0. On an update cycle, the bits being loaded are the ones in effect.
- R9: With the sweep bit active, the delta word is added to the frequency accumulator once every (ramp word + 1) clocks, in a single cycle. Without the sweep bit, the frequency accumulator holds its value. A clear on the same cycle as a step wins over the step.
- R10: When the active control bit 5 is 0, a ramp-rate write takes effect at the next edge. When it is 1, the new ramp-rate word waits for an update strobe.
- R11: A cycle with `sync_clr` high clears all holding and active registers, the control word, both accumulators and the ramp counter, and selects profile 0.
- R12: A write made in the same cycle as an update strobe goes to the holding register only and becomes active at the following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_clr | input | 1 | Synchronous master clear |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| upd_stb | input | 1 | Update strobe: holding registers become active |
| prof_sel | input | 2 | Profile select |
| phase_word | output | 14 | Offset-adjusted phase for the lookup stage |

## Verification
Two collisions matter most.

The first is an update strobe that auto-clears the frequency accumulator landing on the same cycle as a ramp step. The bench provokes it by issuing strobes at a sliding offset against a short ramp period while sweeping. It judges the result by the phase output, whose increment reveals whether the cleared accumulator took the step.

The second is a write issued together with a strobe. It is judged by the output staying on the old word until a later strobe. In both cases, every cycle is compared against an independent behavioural model.

// File: rtl/dds_pkg.sv
package dds_pkg;
  // control word, bit 0 is sweep_en
  typedef struct packed {
    logic ramp_wait;   // bit 5
    logic clr_phase;   // bit 4
    logic clr_freq;    // bit 3
    logic aclr_phase;  // bit 2
    logic aclr_freq;   // bit 1
    logic sweep_en;    // bit 0
  } dds_ctrl_t;

  localparam int CTRL_W = $bits(dds_ctrl_t);
endpackage

// File: rtl/dds_rst_sync.sv
module dds_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/dds_regbank.sv
module dds_regbank
  import dds_pkg::*;
#(
  parameter int NPROF  = 4,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 14,
  parameter int RAMP_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sync_clr,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [ACC_W-1:0]            wr_data,
  input  logic                        upd_stb,
  output logic [NPROF-1:0][ACC_W-1:0] act_ftw,
  output logic [NPROF-1:0][OUT_W-1:0] act_poff,
  output logic [ACC_W-1:0]            act_dftw,
  output logic [RAMP_W-1:0]           act_ramp,
  output dds_ctrl_t                   act_ctrl,
  output dds_ctrl_t                   hold_ctrl
);
  localparam logic [ADDR_W-1:0] A_DFTW = ADDR_W'(2 * NPROF);
  localparam logic [ADDR_W-1:0] A_RAMP = ADDR_W'(2 * NPROF + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * NPROF + 2);
  localparam logic [ACC_W-1:0]  FTW_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] ftw_wr;
  assign ftw_wr = (wr_data > FTW_MAX) ? FTW_MAX : wr_data;

  // per-profile holding and active words
  for (genvar i = 0; i < NPROF; i++) begin : g_prof
    logic             hit_f, hit_p;
    logic [ACC_W-1:0] hf_q, hf_d, af_q, af_d;
    logic [OUT_W-1:0] hp_q, hp_d, ap_q, ap_d;

    assign hit_f = wr_en && (wr_addr == ADDR_W'(i));
    assign hit_p = wr_en && (wr_addr == ADDR_W'(NPROF + i));

    always_comb begin
      hf_d = hit_f ? ftw_wr : hf_q;
      hp_d = hit_p ? wr_data[OUT_W-1:0] : hp_q;
      af_d = upd_stb ? hf_q : af_q;
      ap_d = upd_stb ? hp_q : ap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hf_q <= '0; hp_q <= '0; af_q <= '0; ap_q <= '0;
      end else if (sync_clr) begin
        hf_q <= '0; hp_q <= '0; af_q <= '0; ap_q <= '0;
      end else begin
        hf_q <= hf_d; hp_q <= hp_d; af_q <= af_d; ap_q <= ap_d;
      end
    end

    assign act_ftw[i]  = af_q;
    assign act_poff[i] = ap_q;
  end

  // sweep and control words
  logic [ACC_W-1:0]  hd_q, hd_d, ad_q, ad_d;
  logic [RAMP_W-1:0] hr_q, hr_d, ar_q, ar_d;
  dds_ctrl_t         hc_q, hc_d, ac_q, ac_d;
  logic              hit_d, hit_r, hit_c;

  assign hit_d = wr_en && (wr_addr == A_DFTW);
  assign hit_r = wr_en && (wr_addr == A_RAMP);
  assign hit_c = wr_en && (wr_addr == A_CTRL);

  always_comb begin
    hd_d = hit_d ? wr_data : hd_q;
    hr_d = hit_r ? wr_data[RAMP_W-1:0] : hr_q;
    hc_d = hit_c ? dds_ctrl_t'(wr_data[CTRL_W-1:0]) : hc_q;
    ad_d = upd_stb ? hd_q : ad_q;
    ac_d = upd_stb ? hc_q : ac_q;
    if (hit_r && !ac_q.ramp_wait) ar_d = wr_data[RAMP_W-1:0];
    else if (upd_stb)             ar_d = hr_q;
    else                          ar_d = ar_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q <= '0; hr_q <= '0; hc_q <= '0; ad_q <= '0; ar_q <= '0; ac_q <= '0;
    end else if (sync_clr) begin
      hd_q <= '0; hr_q <= '0; hc_q <= '0; ad_q <= '0; ar_q <= '0; ac_q <= '0;
    end else begin
      hd_q <= hd_d; hr_q <= hr_d; hc_q <= hc_d; ad_q <= ad_d; ar_q <= ar_d; ac_q <= ac_d;
    end
  end

  assign act_dftw  = ad_q;
  assign act_ramp  = ar_q;
  assign act_ctrl  = ac_q;
  assign hold_ctrl = hc_q;
endmodule

// File: rtl/dds_ramp_timer.sv
module dds_ramp_timer #(
  parameter int RAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              run,
  input  logic [RAMP_W-1:0] reload,
  output logic              step
);
  logic [RAMP_W-1:0] cnt_q, cnt_d;

  assign step = run && (cnt_q == '0);

  always_comb begin
    if (!run || cnt_q == '0) cnt_d = reload;
    else                     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sync_clr) cnt_q <= '0;
    else               cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dds_accum.sv
module dds_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic [ACC_W-1:0] ftw,
  input  logic             sweep_en,
  input  logic [ACC_W-1:0] dftw,
  input  logic             step,
  input  logic             zero_phase,
  input  logic             zero_freq,
  output logic [ACC_W-1:0] phase_acc,
  output logic [ACC_W-1:0] freq_acc
);
  logic [ACC_W-1:0] ph_d, fr_d, inc;

  assign inc = ftw + (sweep_en ? freq_acc : '0);

  always_comb begin
    ph_d = zero_phase ? '0 : phase_acc + inc;
    if (zero_freq) fr_d = '0;
    else if (step) fr_d = freq_acc + dftw;
    else           fr_d = freq_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_acc <= '0; freq_acc <= '0;
    end else if (sync_clr) begin
      phase_acc <= '0; freq_acc <= '0;
    end else begin
      phase_acc <= ph_d; freq_acc <= fr_d;
    end
  end
endmodule

// File: rtl/dds_accum_core.sv
module dds_accum_core
  import dds_pkg::*;
#(
  parameter int NPROF  = 4,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 14,
  parameter int RAMP_W = 16,
  parameter int ADDR_W = 4,
  localparam int PROF_W = $clog2(NPROF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              upd_stb,
  input  logic [PROF_W-1:0] prof_sel,
  output logic [OUT_W-1:0]  phase_word
);
  logic                        rst_sync_n;
  logic [NPROF-1:0][ACC_W-1:0] act_ftw;
  logic [NPROF-1:0][OUT_W-1:0] act_poff;
  logic [ACC_W-1:0]            act_dftw, phase_acc, freq_acc;
  logic [RAMP_W-1:0]           act_ramp;
  dds_ctrl_t                   act_ctrl, hold_ctrl, ctrl_now;
  logic [PROF_W-1:0]           prof_q;
  logic                        step, zero_phase, zero_freq;

  dds_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  dds_regbank #(.NPROF(NPROF), .ACC_W(ACC_W), .OUT_W(OUT_W),
                .RAMP_W(RAMP_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .sync_clr(sync_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .upd_stb(upd_stb),
    .act_ftw(act_ftw), .act_poff(act_poff), .act_dftw(act_dftw),
    .act_ramp(act_ramp), .act_ctrl(act_ctrl), .hold_ctrl(hold_ctrl));

  dds_ramp_timer #(.RAMP_W(RAMP_W)) u_ramp (
    .clk(clk), .rst_n(rst_sync_n), .sync_clr(sync_clr),
    .run(act_ctrl.sweep_en), .reload(act_ramp), .step(step));

  // the control value that is in effect during an update cycle is the one being loaded
  assign ctrl_now   = upd_stb ? hold_ctrl : act_ctrl;
  assign zero_phase = ctrl_now.clr_phase || (upd_stb && ctrl_now.aclr_phase);
  assign zero_freq  = ctrl_now.clr_freq  || (upd_stb && ctrl_now.aclr_freq);

  dds_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .sync_clr(sync_clr),
    .ftw(act_ftw[prof_q]), .sweep_en(act_ctrl.sweep_en), .dftw(act_dftw),
    .step(step), .zero_phase(zero_phase), .zero_freq(zero_freq),
    .phase_acc(phase_acc), .freq_acc(freq_acc));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   prof_q <= '0;
    else if (sync_clr) prof_q <= '0;
    else               prof_q <= prof_sel;
  end

  assign phase_word = phase_acc[ACC_W-1 -: OUT_W] + act_poff[prof_q];
endmodule

// File: rtl/dds_accum_core_chk.sv
module dds_accum_core_chk #(
  parameter int NPROF = 4,
  parameter int ACC_W = 32
) (
  input logic                        clk,
  input logic                        rst_ok,
  input logic                        sync_clr,
  input logic                        upd_stb,
  input logic                        act_sweep,
  input logic                        act_clr_freq,
  input logic                        act_clr_phase,
  input logic                        hold_aclr_freq,
  input logic                        hold_aclr_phase,
  input logic [ACC_W-1:0]            phase_acc,
  input logic [ACC_W-1:0]            freq_acc,
  input logic [NPROF-1:0][ACC_W-1:0] act_ftw
);
  localparam logic [ACC_W-1:0] FTW_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  // R8
  phase_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (act_clr_phase && !upd_stb) |=> (phase_acc == '0));

  // R8
  freq_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (act_clr_freq && !upd_stb) |=> (freq_acc == '0));

  // R6
  phase_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (upd_stb && hold_aclr_phase) |=> (phase_acc == '0));

  // R6
  freq_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (upd_stb && hold_aclr_freq) |=> (freq_acc == '0));

  // R9
  freq_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!act_sweep && !act_clr_freq && !upd_stb && !sync_clr) |=> $stable(freq_acc));

  // R2
  active_ftw_buffered_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!upd_stb && !sync_clr) |=> $stable(act_ftw));

  for (genvar i = 0; i < NPROF; i++) begin : g_clamp
    // R3
    ftw_clamp_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      act_ftw[i] <= FTW_MAX);
  end
endmodule

bind dds_accum_core dds_accum_core_chk #(.NPROF(NPROF), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .sync_clr(sync_clr), .upd_stb(upd_stb),
  .act_sweep(act_ctrl.sweep_en), .act_clr_freq(act_ctrl.clr_freq),
  .act_clr_phase(act_ctrl.clr_phase), .hold_aclr_freq(hold_ctrl.aclr_freq),
  .hold_aclr_phase(hold_ctrl.aclr_phase), .phase_acc(phase_acc),
  .freq_acc(freq_acc), .act_ftw(act_ftw));

// File: tb/tb_dds_accum_core.sv
module tb_dds_accum_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_clr = 1'b0, wr_en = 1'b0, upd_stb = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  prof_sel = '0;
  logic [13:0] phase_word;

  dds_accum_core dut (.clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .upd_stb(upd_stb), .prof_sel(prof_sel),
    .phase_word(phase_word));

  always #10 clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference model
  logic [31:0] m_hftw [4], m_aftw [4];
  logic [13:0] m_hpoff [4], m_apoff [4];
  logic [31:0] m_hd, m_ad, m_ph, m_fr;
  logic [15:0] m_hr, m_ar, m_cnt;
  logic [5:0]  m_hc, m_ac;
  logic [1:0]  m_prof;
  int          m_rs;

  task automatic m_clear();
    for (int i = 0; i < 4; i++) begin
      m_hftw[i] = 0; m_aftw[i] = 0; m_hpoff[i] = 0; m_apoff[i] = 0;
    end
    m_hd = 0; m_ad = 0; m_ph = 0; m_fr = 0; m_hr = 0; m_ar = 0; m_cnt = 0;
    m_hc = 0; m_ac = 0; m_prof = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [5:0]  cn;
    logic [31:0] inc, nph, nfr;
    logic [15:0] ncnt;
    logic        stp, imm;
    if (!rst_n) begin
      m_rs = 0; m_clear();
    end else if (m_rs < 2) begin
      m_rs++; m_clear();
    end else if (sync_clr) begin
      m_clear();
    end else begin
      cn   = upd_stb ? m_hc : m_ac;
      inc  = m_aftw[m_prof] + (m_ac[0] ? m_fr : 32'd0);
      stp  = m_ac[0] && (m_cnt == 0);
      nph  = (cn[4] || (upd_stb && cn[2])) ? 32'd0 : m_ph + inc;
      if (cn[3] || (upd_stb && cn[1])) nfr = 0;
      else if (stp)                    nfr = m_fr + m_ad;
      else                             nfr = m_fr;
      ncnt = (!m_ac[0] || m_cnt == 0) ? m_ar : m_cnt - 16'd1;
      imm  = wr_en && wr_addr == 4'd9 && !m_ac[5];
      if (upd_stb) begin
        for (int i = 0; i < 4; i++) begin
          m_aftw[i] = m_hftw[i]; m_apoff[i] = m_hpoff[i];
        end
        m_ad = m_hd; m_ar = m_hr; m_ac = m_hc;
      end
      if (imm) m_ar = wr_data[15:0];
      if (wr_en) begin
        if (wr_addr < 4)       m_hftw[wr_addr] = (wr_data > 32'h8000_0000) ? 32'h8000_0000 : wr_data;
        else if (wr_addr < 8)  m_hpoff[wr_addr-4] = wr_data[13:0];
        else if (wr_addr == 8) m_hd = wr_data;
        else if (wr_addr == 9) m_hr = wr_data[15:0];
        else if (wr_addr == 10) m_hc = wr_data[5:0];
      end
      m_prof = prof_sel; m_ph = nph; m_fr = nfr; m_cnt = ncnt;
    end
  end

  function automatic logic [13:0] m_out();
    return m_ph[31:18] + m_apoff[m_prof];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(cur_req, 32'(phase_word), 32'(m_out()));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic upd();
    upd_stb = 1'b1;
    step();
    upd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'(phase_word), 32'd0);
    rst_n = 1'b1;
    cur_req = "R1"; idle(4);
    check("R1", 32'(phase_word), 32'd0);

    // writes stay invisible until the strobe
    cur_req = "R2";
    wr(4'd0, 32'h0100_0000);
    idle(3);
    check("R2", 32'(phase_word), 32'd0);
    upd(); idle(5);

    cur_req = "R5";
    wr(4'd4, 32'h0000_0123); upd(); idle(4);

    // profile switch, write does not select
    cur_req = "R4";
    wr(4'd1, 32'h0040_0000); wr(4'd5, 32'h0000_2000); upd(); idle(2);
    prof_sel = 2'd1; idle(5);
    prof_sel = 2'd2; idle(3);
    prof_sel = 2'd0; idle(2);

    // sticky phase clear: output equals the offset only
    cur_req = "R8";
    wr(4'd10, 32'h10); upd(); idle(4);
    check("R8", 32'(phase_word), 32'h0123);
    wr(4'd10, 32'h0); upd(); idle(4);

    cur_req = "R7";
    wr(4'd0, 32'h0300_0000); upd(); idle(6);

    cur_req = "R11";
    sync_clr = 1'b1; prof_sel = 2'd0; step(); sync_clr = 1'b0;
    check("R11", 32'(phase_word), 32'd0);
    idle(3);

    // clamp: tuning word maps to half-turn per clock
    cur_req = "R3";
    wr(4'd10, 32'h04); wr(4'd0, 32'hFFFF_FFFF); upd();
    check("R3", 32'(phase_word), 32'd0);
    step(); check("R3", 32'(phase_word), 32'h2000);
    step(); check("R3", 32'(phase_word), 32'h0000);
    idle(3);

    cur_req = "R6";
    wr(4'd0, 32'h0123_4567); wr(4'd10, 32'h0); upd(); idle(5);
    wr(4'd10, 32'h06); upd(); idle(5);

    // sweep with a short ramp period
    cur_req = "R9";
    sync_clr = 1'b1; step(); sync_clr = 1'b0;
    wr(4'd0, 32'h0); wr(4'd8, 32'h0010_0000); wr(4'd9, 32'd3);
    wr(4'd10, 32'h01); upd(); idle(20);
    wr(4'd10, 32'h09); upd(); idle(5);
    wr(4'd10, 32'h01); upd(); idle(10);

    // strobe with frequency auto-clear at sliding offsets against ramp steps
    cur_req = "R9";
    wr(4'd10, 32'h03);
    for (int k = 0; k < 5; k++) begin
      idle(k); upd(); idle(2);
    end
    idle(6);

    cur_req = "R10";
    wr(4'd10, 32'h01); upd(); idle(2);
    wr(4'd9, 32'd1); idle(8);
    wr(4'd10, 32'h21); upd(); idle(2);
    wr(4'd9, 32'd5); idle(10);
    upd(); idle(14);

    // write together with strobe
    cur_req = "R12";
    wr(4'd10, 32'h04); upd(); idle(2);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h0800_0000; upd_stb = 1'b1;
    step();
    wr_en = 1'b0; upd_stb = 1'b0;
    idle(4);
    upd(); idle(4);

    cur_req = "R11";
    wr(4'd2, 32'h0222_0000); prof_sel = 2'd2; idle(3);
    sync_clr = 1'b1; step(); sync_clr = 1'b0;
    check("R11", 32'(phase_word), 32'd0);
    upd(); idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule